// File: doc/BRIEF.md
# Strap-addressed I2C configuration slave with indirect fuse readback

This block answers on a two-wire I2C-compatible bus as a slave and holds a small bank of configuration registers. The system clock oversamples the bus lines through synchronizer flops and must run at ten times the SCL rate or faster. The slave pulls SDA low through an output-enable pin and never drives it high. One strap input selects between two bus addresses, so two copies can share a bus. A write transfer carries a register pointer in its first data byte and then register data. A read transfer returns bytes starting at the current pointer. The pointer advances after every byte in both directions.

The second-to-last register slot selects one column of a constant fuse array. The last slot returns the byte of that selected column. The same selection feeds the trim output bus, which carries column 0 (the trim bits) whenever the select is zero. Any other selection moves the trim bus to that column's data for as long as the selection is held.

The bus has no back-pressure. The slave never stretches SCL. Every byte is committed or loaded in the system clock cycle in which its last SCL falling edge is seen, so no valid/ready handshake is needed at the edge of the block.

Top module: `fuse_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 1,1,0,0,0,strap,0 (bytes 0xC0/0xC1 for strap 0, 0xC4/0xC5 for strap 1), with bit 0 as R/W (0 = write, 1 = read). For any other address it leaves SDA released for the rest of the transfer.
- R2: A falling SDA while SCL is high (START) restarts address reception from bit 0, including in the middle of a byte and without a STOP before it. A rising SDA while SCL is high (STOP) returns the slave to idle.
- R3: In a write transfer, the first data byte loads the register pointer (its low 4 bits). Each later data byte is stored at the pointer, and the pointer then advances by one. The slave acknowledges every data byte.
- R4: In a read transfer, the slave shifts out the byte at the pointer MSB first, changing SDA only while SCL is low. The pointer advances after each byte, and the next byte follows while the master acknowledges.
- R5: A NACK from the master after a read byte ends the transmission. SDA stays released through later SCL pulses until the next START or STOP.
- R6: Register 0x0E holds the fuse column select and reads back as written. Register 0x0F returns the fuse byte of the column given by the low 4 bits of 0x0E. Writes to 0x0F change nothing, but they still advance the pointer.
- R7: `trim_out` always shows the fuse column named by register 0x0E. It changes only after a write to 0x0E and shows column 0 after reset.
- R8: After reset, SDA is released, all configuration registers read zero and the pointer is zero.
- R9: The pointer wraps from 0x0F to 0x00 in both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap | input | 1 | Address select strap, becomes address bit 1 |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| trim_out | output | 8 | Fuse column selected by register 0x0E |
| cfg_out | output | 112 | Registers 0x00..0x0D, register n at bits 8n+7:8n |

## Verification
The riskiest coincidence is the commit of a data byte into the select register at 0x0E: in that one clock the select moves, the trim bus follows it and the pointer steps onto 0x0F. The bench provokes it by writing a column number and then reading 0x0E, 0x0F and, after the wrap, 0x00 in one burst. It also writes 0x0F and 0x00 back to back. A second coincidence is a START that arrives while a data byte is half shifted in. The bench forces one after four bits and then reads back the pointer it set just before. A behavioural register model follows every transfer and is compared with `trim_out` and `cfg_out` on every clock while SCL is high.

// File: rtl/fi2c_pkg.sv
package fi2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } fi2c_state_e;

  localparam int unsigned BYTE_W = 8;
  localparam logic [4:0] ADDR_UPPER = 5'b11000;
endpackage

// File: rtl/fi2c_line_sync.sv
module fi2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_in};
      sda_sh <= {sda_sh[STAGES-2:0], sda_in};
      scl_d  <= scl_sh[STAGES-1];
      sda_d  <= sda_sh[STAGES-1];
    end
  end

  assign scl_q     = scl_sh[STAGES-1];
  assign sda_q     = sda_sh[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/fi2c_link.sv
module fi2c_link
  import fi2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap,
  input  logic              scl_q,
  input  logic              sda_q,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              ptr_load,
  output logic              wr_en,
  output logic              rd_req,
  output logic [BYTE_W-1:0] wr_data
);
  fi2c_state_e state;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] rx, tx;
  logic              rw, first, m_ack;
  logic [6:0]        own_addr;
  logic              byte_end;

  assign own_addr = {ADDR_UPPER, strap, 1'b0};
  assign byte_end = scl_fall && (bitcnt == 4'd8);
  assign ptr_load = (state == ST_WDATA) && byte_end && first;
  assign wr_en    = (state == ST_WDATA) && byte_end && !first;
  assign wr_data  = rx;
  assign rd_req   = scl_fall && (((state == ST_ADDR_ACK) && rw) ||
                                 ((state == ST_RACK) && m_ack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      rx     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      first  <= 1'b0;
      m_ack  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            rx     <= {rx[BYTE_W-2:0], sda_q};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (rx[7:1] == own_addr) begin
                state  <= ST_ADDR_ACK;
                sda_oe <= 1'b1;
                rw     <= rx[0];
                first  <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              state  <= ST_WACK;
              sda_oe <= 1'b1;
              first  <= 1'b0;
            end
          end
        end
        ST_ADDR_ACK, ST_WACK: begin
          if (scl_fall) begin
            if (state == ST_ADDR_ACK && rw) begin
              state  <= ST_RDATA;
              tx     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
            end else begin
              state  <= ST_WDATA;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              state  <= ST_RACK;
              sda_oe <= 1'b0;
              bitcnt <= '0;
            end else begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_q;
          end else if (scl_fall) begin
            if (m_ack) begin
              state  <= ST_RDATA;
              tx     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R2: the slave never starts pulling SDA while SCL is high (no false START)
  p_oe_rise_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_q);

  // R2: framing counter never passes nine bit slots
  p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt <= 4'd8);

  // R1: during the address ACK high phase SDA is held low
  p_ack_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK && scl_q) |-> sda_oe);

  // R5: an idle slave leaves SDA released
  p_idle_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/fi2c_regs.sv
module fi2c_regs
  import fi2c_pkg::*;
#(
  parameter int unsigned NREG = 16,
  parameter int unsigned NCOL = 16,
  parameter logic [NCOL*BYTE_W-1:0] FUSE_BITS = {NCOL{8'h5A}}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ptr_load,
  input  logic                         wr_en,
  input  logic                         rd_req,
  input  logic [BYTE_W-1:0]            wr_data,
  output logic [BYTE_W-1:0]            rd_data,
  output logic [(NREG-2)*BYTE_W-1:0]   cfg_flat,
  output logic [BYTE_W-1:0]            trim_out
);
  localparam int unsigned PW = $clog2(NREG);
  localparam int unsigned CW = $clog2(NCOL);
  localparam logic [PW-1:0] P_FADDR = PW'(NREG - 2);
  localparam logic [PW-1:0] P_FREAD = PW'(NREG - 1);

  logic [PW-1:0]            ptr;
  logic [BYTE_W-1:0]        fsel;
  logic [BYTE_W-1:0]        fuse_col;
  logic [NREG*BYTE_W-1:0]   rd_vec;

  for (genvar i = 0; i < NREG - 2; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_flat[i*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && ptr == PW'(i))
        cfg_flat[i*BYTE_W +: BYTE_W] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel <= '0;
      ptr  <= '0;
    end else begin
      if (wr_en && ptr == P_FADDR) fsel <= wr_data;
      if (ptr_load)            ptr <= wr_data[PW-1:0];
      else if (wr_en || rd_req) ptr <= ptr + 1'b1;
    end
  end

  assign fuse_col = FUSE_BITS[{fsel[CW-1:0], 3'b000} +: BYTE_W];
  assign trim_out = fuse_col;
  assign rd_vec   = {fuse_col, fsel, cfg_flat};
  assign rd_data  = rd_vec[{ptr, 3'b000} +: BYTE_W];

  // R3: each committed byte or loaded read byte steps the pointer by one
  p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || rd_req) && !ptr_load) |=> ptr == PW'($past(ptr) + 1'b1));

  // R7: trim bus moves only after a write to the select register
  p_trim_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && ptr == P_FADDR) |=> $stable(trim_out));

  // R6: a write aimed at the fuse-read slot leaves all storage unchanged
  p_fread_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == P_FREAD) |=> ($stable(cfg_flat) && $stable(fsel)));
endmodule

// File: rtl/fuse_i2c_slave.sv
module fuse_i2c_slave
  import fi2c_pkg::*;
#(
  parameter int unsigned NREG        = 16,
  parameter int unsigned NCOL        = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [NCOL*BYTE_W-1:0] FUSE_BITS = {NCOL{8'h5A}}
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strap,
  input  logic                        scl_in,
  input  logic                        sda_in,
  output logic                        sda_oe,
  output logic [BYTE_W-1:0]           trim_out,
  output logic [(NREG-2)*BYTE_W-1:0]  cfg_out
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, wr_en, rd_req;
  logic [BYTE_W-1:0] wr_data, rd_data;

  fi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  fi2c_link u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap     (strap),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .sda_oe    (sda_oe),
    .ptr_load  (ptr_load),
    .wr_en     (wr_en),
    .rd_req    (rd_req),
    .wr_data   (wr_data)
  );

  fi2c_regs #(
    .NREG      (NREG),
    .NCOL      (NCOL),
    .FUSE_BITS (FUSE_BITS)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (ptr_load),
    .wr_en    (wr_en),
    .rd_req   (rd_req),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .cfg_flat (cfg_out),
    .trim_out (trim_out)
  );
endmodule

// File: tb/fuse_i2c_slave_test.sv
module fuse_i2c_slave_test;
  localparam int Q = 10;
  localparam logic [127:0] FUSE_PAT = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic m_scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_oe;
  logic [7:0] trim_out;
  logic [111:0] cfg_out;
  wire sda_bus = ~(m_low | sda_oe);

  always #10 clk = ~clk;

  fuse_i2c_slave #(.NREG(16), .NCOL(16), .SYNC_STAGES(2), .FUSE_BITS(FUSE_PAT)) uut (
    .clk(clk), .rst_n(rst_n), .strap(strap), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .trim_out(trim_out), .cfg_out(cfg_out)
  );

  int checks = 0;
  int fails = 0;
  logic [7:0] mregs [14];
  logic [7:0] mfsel;
  int mptr;
  bit cmp_on = 1'b0;

  function automatic logic [7:0] fcol(input int c);
    return FUSE_PAT[c*8 +: 8];
  endfunction

  function automatic void model_write(input logic [7:0] d);
    if (mptr == 14) mfsel = d;
    else if (mptr != 15) mregs[mptr] = d;
    mptr = (mptr + 1) % 16;
  endfunction

  function automatic logic [7:0] model_read();
    logic [7:0] e;
    if (mptr == 14) e = mfsel;
    else if (mptr == 15) e = fcol(int'(mfsel[3:0]));
    else e = mregs[mptr];
    mptr = (mptr + 1) % 16;
    return e;
  endfunction

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // per-clock comparison against the register model while SCL is high
  always @(negedge clk) begin
    if (cmp_on && m_scl) begin
      logic [111:0] exp_cfg;
      for (int i = 0; i < 14; i++) exp_cfg[i*8 +: 8] = mregs[i];
      checks++;
      if (trim_out !== fcol(int'(mfsel[3:0])) || cfg_out !== exp_cfg) begin
        fails++;
        $display("FAIL R7/R3 model: got trim %h cfg %h expected trim %h cfg %h",
                 trim_out, cfg_out, fcol(int'(mfsel[3:0])), exp_cfg);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(Q);
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic recv_bit(output logic b);
    m_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  // upd: 0 none, 1 pointer byte, 2 data byte
  task automatic xfer_byte(input logic [7:0] d, input int upd, input logic exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    if (upd == 1) mptr = int'(d[3:0]);
    else if (upd == 2) model_write(d);
    m_low = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    a = ~sda_bus; tick(Q);
    m_scl = 1'b0; tick(Q);
    check_bit(a, exp_ack, req);
  endtask

  task automatic rd_byte(input logic ack, input string req);
    logic [7:0] got;
    logic [7:0] exp;
    logic b;
    exp = model_read();
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      got[i] = b;
    end
    m_low = ack; tick(Q);
    m_scl = 1'b1; tick(2*Q);
    m_scl = 1'b0; tick(Q);
    m_low = 1'b0;
    check8(got, exp, req);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    logic b;
    for (int i = 0; i < 14; i++) mregs[i] = 8'h00;
    mfsel = 8'h00;
    mptr = 0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R8 reset state, R7 column 0 on trim bus
    check_bit(sda_oe, 1'b0, "R8");
    check_bit(cfg_out == '0, 1'b1, "R8");
    check8(trim_out, fcol(0), "R7");
    cmp_on = 1'b1;

    // R1 R3: write burst at strap 0
    bus_start();
    xfer_byte(8'hC0, 0, 1'b1, "R1");
    xfer_byte(8'h02, 1, 1'b1, "R3");
    xfer_byte(8'hAA, 2, 1'b1, "R3");
    xfer_byte(8'h55, 2, 1'b1, "R3");
    xfer_byte(8'h3C, 2, 1'b1, "R3");
    bus_stop();

    // R2 repeated START into read, R4 burst, R5 NACK
    bus_start();
    xfer_byte(8'hC0, 0, 1'b1, "R1");
    xfer_byte(8'h02, 1, 1'b1, "R3");
    bus_start();
    xfer_byte(8'hC1, 0, 1'b1, "R2");
    rd_byte(1'b1, "R4");
    rd_byte(1'b1, "R4");
    rd_byte(1'b0, "R5");
    recv_bit(b);
    check_bit(b, 1'b1, "R5");
    recv_bit(b);
    check_bit(b, 1'b1, "R5");
    bus_stop();

    // R1 foreign address: silent for the whole transfer
    bus_start();
    xfer_byte(8'hC4, 0, 1'b0, "R1");
    xfer_byte(8'h00, 0, 1'b0, "R1");
    bus_stop();

    // R1 strap at 1
    strap = 1'b1;
    tick(Q);
    bus_start();
    xfer_byte(8'hC0, 0, 1'b0, "R1");
    bus_stop();
    bus_start();
    xfer_byte(8'hC4, 0, 1'b1, "R1");
    xfer_byte(8'h0E, 1, 1'b1, "R3");
    xfer_byte(8'h05, 2, 1'b1, "R6");
    bus_stop();
    check8(trim_out, fcol(5), "R7");

    // R6 select readback and fuse column, R9 wrap on read
    bus_start();
    xfer_byte(8'hC4, 0, 1'b1, "R1");
    xfer_byte(8'h0E, 1, 1'b1, "R3");
    bus_start();
    xfer_byte(8'hC5, 0, 1'b1, "R2");
    rd_byte(1'b1, "R6");
    rd_byte(1'b1, "R6");
    rd_byte(1'b0, "R9");
    bus_stop();

    // R6 write to fuse-read slot ignored, R9 wrap on write
    bus_start();
    xfer_byte(8'hC4, 0, 1'b1, "R1");
    xfer_byte(8'h0F, 1, 1'b1, "R3");
    xfer_byte(8'hFF, 2, 1'b1, "R6");
    xfer_byte(8'h77, 2, 1'b1, "R9");
    bus_stop();
    bus_start();
    xfer_byte(8'hC4, 0, 1'b1, "R1");
    xfer_byte(8'h0F, 1, 1'b1, "R3");
    bus_start();
    xfer_byte(8'hC5, 0, 1'b1, "R2");
    rd_byte(1'b1, "R6");
    rd_byte(1'b0, "R9");
    bus_stop();

    // R2 START inside a half-shifted data byte
    bus_start();
    xfer_byte(8'hC4, 0, 1'b1, "R1");
    xfer_byte(8'h02, 1, 1'b1, "R3");
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    bus_start();
    xfer_byte(8'hC5, 0, 1'b1, "R2");
    rd_byte(1'b0, "R2");
    bus_stop();

    // R7 select back to the trim column
    bus_start();
    xfer_byte(8'hC4, 0, 1'b1, "R1");
    xfer_byte(8'h0E, 1, 1'b1, "R3");
    xfer_byte(8'h00, 2, 1'b1, "R7");
    bus_stop();
    check8(trim_out, fcol(0), "R7");
    check_bit(sda_oe, 1'b0, "R5");

    cmp_on = 1'b0;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R2 watchdog: got hung run expected completion");
    summary();
    $finish;
  end
endmodule